// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block is a clocked model of the write side of a byte-wide nonvolatile memory with a 15-bit address. A host drives it the way it would drive an asynchronous SRAM. It uses active-low chip enable, output enable and write enable, plus an address and a data byte. Each write strobe drops one byte into a 64-entry page buffer, and each buffer entry has its own valid flag. Address bits 14:6 name the page and bits 5:0 name the byte inside it.

The first accepted byte opens a load window. The window stays open as long as each new strobe follows the previous one within `T_BLC` clock cycles. Once the strobes stop, the block raises `busy` for `T_WC` cycles. When that time ends, it copies only the flagged bytes into the storage array and leaves the rest of the page alone. A strobe that names a different page from the one being loaded is dropped and sets a sticky error flag.

Reads return stored bytes whenever the block is not busy. Chip enable and write enable are synchronised to the clock before their edges are used. The storage array keeps `STORE_PAGES` pages, selected by the low bits of the page number, so the default elaboration stays small.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is applied and right after it is released, `busy`, `page_err` and `rd_ok` are low.
- R2: A write enable pulse that goes low while chip enable is low and output enable is high loads `din` at `addr`. Once programming has finished, a read of that address returns the byte.
- R3: A chip enable pulse that goes low while write enable is already low loads a byte in the same way.
- R4: The address is taken when the strobe becomes active, which is the later of the two falling enables. The data is taken when the strobe ends, which is the first of the two rising enables. An address change in mid-strobe has no effect, and a data change in mid-strobe is kept.
- R5: Within one window, bytes may come in any order and the same byte may be written more than once; the last value written is the one stored. Bytes of the page that were not loaded keep their earlier contents.
- R6: A strobe whose `addr[14:6]` differs from the page of the open window stores nothing and sets `page_err`. `page_err` stays high until reset.
- R7: A strobe that begins while output enable is low stores nothing and opens no window. The same holds for a strobe that begins while `busy` is high.
- R8: The load window closes once `T_BLC` consecutive cycles pass with no active strobe. `busy` rises only after that, never earlier.
- R9: `busy` stays high for exactly `T_WC` cycles, and no read is served while it is high (`rd_ok` low).
- R10: With chip enable low, output enable low, write enable high and the block not busy, `rd_ok` goes high a few cycles later. `rd_data` then holds the stored byte at `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; the upper bits select the page |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid while `rd_ok` is high |
| rd_ok | output | 1 | A read is being served |
| busy | output | 1 | Programming in progress |
| page_err | output | 1 | Sticky: a strobe for a different page was dropped |

## Verification
The assertions assume that the host keeps `addr` and `oe_n` steady from shortly before a strobe becomes active until the synchronised strobe start is seen. They also assume `din` is steady around the synchronised strobe end, and that every strobe lasts longer than the two-flop synchroniser delay. The stimulus holds each enable low for six cycles and changes address and data only at falling clock edges. The single exception is the deliberate mid-strobe change, which comes well after the start has been detected. Gaps between bytes in one window are kept far below `T_BLC`, so windows close only when the bench intends them to.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } epw_state_e;
endpackage

// File: rtl/epw_strobe.sv
// Synchronises the two enables and marks where the combined strobe starts and stops.
module epw_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic act,
  output logic start,
  output logic stop,
  output logic ce_lo,
  output logic we_hi
);
  logic [1:0] ce_q, ce_d;
  logic [1:0] we_q, we_d;
  logic       act_q;

  always_comb begin
    ce_d  = {ce_q[0], ce_n};
    we_d  = {we_q[0], we_n};
    act   = ~ce_q[1] & ~we_q[1];
    start = act & ~act_q;
    stop  = ~act & act_q;
    ce_lo = ~ce_q[1];
    we_hi = we_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 2'b11;
      we_q  <= 2'b11;
      act_q <= 1'b0;
    end else begin
      ce_q  <= ce_d;
      we_q  <= we_d;
      act_q <= act;
    end
  end
endmodule

// File: rtl/epw_seq.sv
// Load window, page rule, inhibit and program timer.
module epw_seq
  import epw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6,
  parameter int SIDX_W = 2,
  parameter int T_BLC  = 1000,
  parameter int T_WC   = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              start,
  input  logic              stop,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [OFS_W-1:0]  cap_lane,
  output logic [SIDX_W-1:0] prog_page,
  output logic              commit,
  output logic              busy,
  output logic              page_err
);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int BLC_W = $clog2(T_BLC + 1);
  localparam int WC_W  = $clog2(T_WC + 1);

  epw_state_e        st_q, st_d;
  logic [ADDR_W-1:0] cap_q, cap_d;
  logic [PG_W-1:0]   pg_q, pg_d, cap_pg;
  logic              arm_q, arm_d, err_q, err_d;
  logic [BLC_W-1:0]  blc_q, blc_d;
  logic [WC_W-1:0]   wc_q, wc_d;
  logic              same_pg, accept, reject, tmo, wc_end;

  always_comb begin
    cap_pg  = cap_q[ADDR_W-1:OFS_W];
    same_pg = (cap_pg == pg_q);
    accept  = stop & arm_q & ((st_q == ST_IDLE) | ((st_q == ST_LOAD) & same_pg));
    reject  = stop & arm_q & (st_q == ST_LOAD) & ~same_pg;
    tmo     = (st_q == ST_LOAD) & ~act & ~accept & (blc_q == BLC_W'(T_BLC - 1));
    wc_end  = (st_q == ST_PROG) & (wc_q == WC_W'(T_WC - 1));

    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = ST_LOAD;
      ST_LOAD: if (tmo)    st_d = ST_PROG;
      ST_PROG: if (wc_end) st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase

    cap_d = start ? addr : cap_q;

    arm_d = arm_q;
    if (stop || st_q == ST_PROG) arm_d = 1'b0;
    if (start) arm_d = oe_n & (st_q != ST_PROG);

    pg_d  = (accept && st_q == ST_IDLE) ? cap_pg : pg_q;
    err_d = err_q | reject;

    if (act || accept || st_q != ST_LOAD) blc_d = '0;
    else                                  blc_d = blc_q + BLC_W'(1);

    wc_d = (st_q == ST_PROG) ? wc_q + WC_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cap_q <= '0;
      pg_q  <= '0;
      arm_q <= 1'b0;
      err_q <= 1'b0;
      blc_q <= '0;
      wc_q  <= '0;
    end else begin
      st_q  <= st_d;
      cap_q <= cap_d;
      pg_q  <= pg_d;
      arm_q <= arm_d;
      err_q <= err_d;
      blc_q <= blc_d;
      wc_q  <= wc_d;
    end
  end

  assign wr_en     = accept;
  assign cap_lane  = cap_q[OFS_W-1:0];
  assign prog_page = pg_q[SIDX_W-1:0];
  assign commit    = wc_end;
  assign busy      = (st_q == ST_PROG);
  assign page_err  = err_q;
endmodule

// File: rtl/epw_page_buf.sv
// One data byte and one valid flag per lane of the page.
module epw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [OFS_W-1:0]                      wr_lane,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  clr,
  output logic [(1<<OFS_W)-1:0][DATA_W-1:0]     lane_data,
  output logic [(1<<OFS_W)-1:0]                 lane_vld
);
  localparam int PAGE_BYTES = 1 << OFS_W;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic hit;
    assign hit = wr_en & (wr_lane == OFS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_data[g] <= '0;
        lane_vld[g]  <= 1'b0;
      end else begin
        if (hit) lane_data[g] <= wr_data;
        if (clr)      lane_vld[g] <= 1'b0;
        else if (hit) lane_vld[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/epw_store.sv
// Behavioural storage, one column per byte lane so a whole page commits in one cycle.
module epw_store #(
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 6,
  parameter int STORE_PAGES = 4,
  parameter int SIDX_W      = 2
) (
  input  logic                              clk,
  input  logic [(1<<OFS_W)-1:0]             wr_vec,
  input  logic [SIDX_W-1:0]                 wr_idx,
  input  logic [(1<<OFS_W)-1:0][DATA_W-1:0] wr_data,
  input  logic [SIDX_W-1:0]                 rd_idx,
  input  logic [OFS_W-1:0]                  rd_lane,
  output logic [DATA_W-1:0]                 rd_data
);
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic [PAGE_BYTES-1:0][DATA_W-1:0] lane_rd;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    logic [DATA_W-1:0] mem_q [STORE_PAGES];
    always_ff @(posedge clk) begin
      if (wr_vec[g]) mem_q[wr_idx] <= wr_data[g];
    end
    assign lane_rd[g] = mem_q[rd_idx];
  end

  assign rd_data = lane_rd[rd_lane];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int OFS_W       = 6,
  parameter int STORE_PAGES = 4,
  parameter int T_BLC       = 1000,
  parameter int T_WC        = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ok,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int SIDX_W     = $clog2(STORE_PAGES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  logic act, start, stop, ce_lo, we_hi;
  logic wr_en, commit;
  logic [OFS_W-1:0]  cap_lane;
  logic [SIDX_W-1:0] prog_page;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] lane_data;
  logic [PAGE_BYTES-1:0]             lane_vld;
  logic [DATA_W-1:0] store_rd;

  epw_strobe u_strobe (
    .clk(clk), .rst_n(srst_n), .ce_n(ce_n), .we_n(we_n),
    .act(act), .start(start), .stop(stop), .ce_lo(ce_lo), .we_hi(we_hi)
  );

  epw_seq #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SIDX_W(SIDX_W), .T_BLC(T_BLC), .T_WC(T_WC)
  ) u_seq (
    .clk(clk), .rst_n(srst_n), .act(act), .start(start), .stop(stop),
    .oe_n(oe_n), .addr(addr), .wr_en(wr_en), .cap_lane(cap_lane),
    .prog_page(prog_page), .commit(commit), .busy(busy), .page_err(page_err)
  );

  epw_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_lane(cap_lane),
    .wr_data(din), .clr(commit), .lane_data(lane_data), .lane_vld(lane_vld)
  );

  epw_store #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .STORE_PAGES(STORE_PAGES), .SIDX_W(SIDX_W)
  ) u_store (
    .clk(clk), .wr_vec(lane_vld & {PAGE_BYTES{commit}}), .wr_idx(prog_page),
    .wr_data(lane_data), .rd_idx(addr[OFS_W +: SIDX_W]),
    .rd_lane(addr[OFS_W-1:0]), .rd_data(store_rd)
  );

  // read port
  logic              rd_go;
  logic              rd_ok_q;
  logic [DATA_W-1:0] rd_q;
  assign rd_go = ce_lo & we_hi & ~oe_n & ~busy;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_ok_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      rd_ok_q <= rd_go;
      if (rd_go) rd_q <= store_rd;
    end
  end

  assign rd_ok   = rd_ok_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int T_BLC = 1000,
  parameter int T_WC  = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic busy,
  input logic rd_ok,
  input logic page_err,
  input logic commit
);
  localparam int IC_W  = $clog2(T_BLC + 4) + 1;
  localparam int RUN_W = $clog2(T_WC + 2) + 1;

  logic [IC_W-1:0]  quiet_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      run_q   <= '0;
    end else begin
      if (!(ce_n | we_n))  quiet_q <= '0;
      else if (~&quiet_q)  quiet_q <= quiet_q + IC_W'(1);
      run_q <= busy ? run_q + RUN_W'(1) : '0;
    end
  end

  AST_BUSY_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> quiet_q >= IC_W'(T_BLC)); // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == RUN_W'(T_WC)); // R9
  AST_NO_READ_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !rd_ok); // R9
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err); // R6
endmodule

bind eeprom_page_writer epw_checker #(.T_BLC(T_BLC), .T_WC(T_WC)) u_epw_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .busy(busy),
  .rd_ok(rd_ok), .page_err(page_err), .commit(commit)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;
  localparam int TB_BLC = 24;
  localparam int TB_WC  = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n;
  logic [14:0] addr;
  logic [7:0]  din;
  logic [7:0]  rd_data;
  logic        rd_ok, busy, page_err;

  int n_tot = 0;
  int n_bad = 0;
  int rd_hi = 0;
  bit rd_prev = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  eeprom_page_writer #(.T_BLC(TB_BLC), .T_WC(TB_WC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rd_data(rd_data), .rd_ok(rd_ok),
    .busy(busy), .page_err(page_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each new read is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_ok) rd_hi++;
      if (rd_ok && !rd_prev) begin
        if (exp_q.size() == 0) begin
          n_tot++; n_bad++;
          $display("FAIL R9 unexpected read actual=%0h expected=none", rd_data);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
    end
    rd_prev = rd_ok;
  end

  task automatic wr_we(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_ce(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b0;
    repeat (6) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R4: address and data both change halfway through the strobe
  task automatic wr_shift(input logic [14:0] a0, input logic [7:0] d0,
                          input logic [14:0] a1, input logic [7:0] d1);
    @(negedge clk); addr = a0; din = d0; oe_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = a1; din = d1;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_inhibit(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b0;
    repeat (6) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] a, input bit expect_it,
                    input logic [7:0] e, input string tag);
    if (expect_it) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(negedge clk); addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    repeat (6) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_prog();
    int n = 0;
    int len = 0;
    while (!busy && n < 500) begin @(negedge clk); n++; end
    chk(busy == 1'b1, "R8 window close", busy, 1);
    while (busy && len < 5000) begin @(negedge clk); len++; end
    chk(len == TB_WC, "R9 busy length", len, TB_WC);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && page_err == 1'b0 && rd_ok == 1'b0, "R1 in reset",
        {busy, page_err, rd_ok}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && page_err == 1'b0 && rd_ok == 1'b0, "R1 after reset",
        {busy, page_err, rd_ok}, 0);

    // prime a byte in page 2
    wr_we(15'h0081, 8'h5A);
    wait_prog();

    // page 1: out of order, CE-controlled byte, overwrite (R2 R3 R5)
    wr_we(15'h0045, 8'h11);
    wr_we(15'h0040, 8'h22);
    wr_ce(15'h0047, 8'h33);
    wr_we(15'h0045, 8'h44);
    repeat (TB_BLC - 6) @(negedge clk);
    chk(busy == 1'b0, "R8 still loading", busy, 0);
    wait_prog();
    rd(15'h0045, 1'b1, 8'h44, "R5 overwrite");
    rd(15'h0040, 1'b1, 8'h22, "R2 we write");
    rd(15'h0047, 1'b1, 8'h33, "R3 ce write");
    rd(15'h0081, 1'b1, 8'h5A, "R10 read page 2");

    // page 1 again with a page-2 intruder (R6, R5 untouched)
    wr_we(15'h0046, 8'h55);
    wr_we(15'h0081, 8'h99);
    chk(page_err == 1'b1, "R6 error raised", page_err, 1);
    wait_prog();
    rd(15'h0046, 1'b1, 8'h55, "R5 new byte");
    rd(15'h0045, 1'b1, 8'h44, "R5 untouched byte");
    rd(15'h0040, 1'b1, 8'h22, "R5 untouched byte");
    rd(15'h0081, 1'b1, 8'h5A, "R6 dropped write");

    // R4: address at start, data at end
    wr_shift(15'h00C2, 8'h10, 15'h00C3, 8'h77);
    wait_prog();
    rd(15'h00C2, 1'b1, 8'h77, "R4 capture points");

    // R7: output enable low inhibits
    wr_inhibit(15'h0045, 8'hEE);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < TB_BLC + TB_WC; i++) begin
        @(negedge clk);
        if (busy) seen = 1'b1;
      end
      chk(!seen, "R7 no window after inhibit", seen, 0);
    end
    rd(15'h0045, 1'b1, 8'h44, "R7 inhibited byte");

    // R7 and R9: strobe and read while busy
    wr_we(15'h0040, 8'h01);
    begin
      int n = 0;
      while (!busy && n < 500) begin @(negedge clk); n++; end
    end
    wr_we(15'h0040, 8'hBB);
    rd_hi = 0;
    rd(15'h0040, 1'b0, 8'h00, "");
    chk(rd_hi == 0, "R9 no read while busy", rd_hi, 0);
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    begin
      int n = 0;
      while (busy && n < 500) begin @(negedge clk); n++; end
    end
    repeat (TB_BLC + 10) @(negedge clk);
    chk(busy == 1'b0, "R7 no window from busy strobe", busy, 0);
    rd(15'h0040, 1'b1, 8'h01, "R7 busy strobe dropped");

    chk(page_err == 1'b1, "R6 sticky", page_err, 1);
    chk(exp_q.size() == 0, "R10 all reads served", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule